// File: doc/BRIEF.md
# SerDes Indirect Register Bridge

This block gives a host access to the internal registers of several two-lane SerDes macros through four registers on the host side. The host picks a SerDes instance in a select register. It writes a target word into an address register: an enable bit, a lane field and a 16-bit register offset. It then starts one command by writing the command/data register with exactly one of two flag bits set. The bridge runs that command on a synchronous register port on the SerDes side. It holds the write or read strobe until the macro signals ready.

A write command is complete when its flag bit clears. A read command is complete when an acknowledge bit is set in the status register; the returned 16-bit value sits in the low half of that register. When a command targets an address that does not exist, the bridge never starts it. When the macro does not answer within a bounded number of cycles, the bridge abandons the command. Both cases set a sticky error bit that the host can read and clear.

Top module: `sdb_bridge`

## Requirements
- R1: After reset all four host registers read as zero, and both SerDes strobes and the lane mask are low.
- R2: Writing the command register (index 1) with bit 31 set and bit 30 clear starts one write. The bridge drives `sd_addr_o` with the address register's bits 15:0 and `sd_wdata_o` with the command word's bits 15:0. It holds `sd_we_o` high until `sd_ready_i`. Bit 31 of the command register reads 1 until the edge where ready is seen, so the host sees it set for exactly N polls when ready comes on the Nth strobe cycle.
- R3: Writing the command register with only bit 30 set starts one read on `sd_re_o`. At the ready edge the bridge captures `sd_rdata_i` into bits 15:0 of the status register (index 2), sets bit 31 of that register and clears command bit 30.
- R4: Lane field bits 24:16 of the address register (index 0) select the lanes: value 0 gives lane mask 2'b01, value 1 gives 2'b10, and 9'h1FF on a write gives 2'b11.
- R5: A read whose lane field is 9'h1FF goes to lane 0 only (mask 2'b01).
- R6: `sd_inst_o` carries the select register (index 3) value while a command runs.
- R7: A command is refused at acceptance when the target does not exist. That is the case when address bit 27 is clear, when the lane field is not 0, 1 or 9'h1FF, or when the select value is NUM_INST or more. A refused command produces no strobe, leaves both flags at 0 and sets the sticky error bit 30 of the status register.
- R8: When ready has not come after TMO strobe cycles, the bridge drops the strobe, clears the flag and sets error bit 30. Ready on the TMO-th cycle still completes normally.
- R9: While a command runs, host writes to the address, select and command registers are ignored. The outstanding command and the register readbacks stay unchanged.
- R10: Issuing a read clears the read acknowledge (status bit 31) at acceptance. The acknowledge stays clear until that read completes.
- R11: A command-register write with both flags set, or with neither set, starts nothing and changes no register.
- R12: Writing the status register with bit 30 set clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host register write enable |
| host_addr_i | input | 2 | Host register index (0 address, 1 command/data, 2 status/read data, 3 select) |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Readback of the indexed register |
| sd_inst_o | output | INST_W | SerDes instance select |
| sd_lane_o | output | NUM_LANES | Lane enable mask, zero when idle |
| sd_addr_o | output | 16 | SerDes register offset |
| sd_wdata_o | output | 16 | SerDes write data |
| sd_we_o | output | 1 | Write strobe, held until ready |
| sd_re_o | output | 1 | Read strobe, held until ready |
| sd_ready_i | input | 1 | SerDes completion |
| sd_rdata_i | input | 16 | SerDes read data |

## Verification
If the timeout counter is off by one, the host sees the flag for one poll too many or too few. This shows up right at the TMO boundary, where ready on the last allowed cycle must still succeed. A lane decode that goes wrong on the broadcast code shows up on the very first strobe cycle as a wrong lane mask. It also shows up when the read data returns, because the bench's SerDes model folds the lane mask and the instance number into that data. If the target registers are not frozen while a command runs, a write made in the middle of a command shows up in the logged transaction, or in a readback taken as soon as the command finishes.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  typedef enum logic [1:0] {
    REG_ADDR = 2'd0,
    REG_CMD  = 2'd1,
    REG_STAT = 2'd2,
    REG_SEL  = 2'd3
  } reg_idx_e;

  typedef enum logic {SEQ_IDLE, SEQ_ACTIVE} seq_state_e;

  localparam int WR_FLAG_BIT = 31;
  localparam int RD_FLAG_BIT = 30;
  localparam int RACK_BIT    = 31;
  localparam int ERR_BIT     = 30;
  localparam int TGT_EN_BIT  = 27;
  localparam int LANE_LSB    = 16;
  localparam int LANE_W      = 9;
  localparam int OFF_W       = 16;
endpackage

// File: rtl/sdb_target_decode.sv
module sdb_target_decode
  import sdb_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int NUM_INST  = 4,
  parameter int SEL_W     = 4
) (
  input  logic                 tgt_en_i,
  input  logic [LANE_W-1:0]    lane_fld_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 rd_i,
  output logic [NUM_LANES-1:0] lane_o,
  output logic                 valid_o
);
  logic                 bcast;
  logic [NUM_LANES-1:0] hit;

  assign bcast = &lane_fld_i;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam logic IS_L0 = (i == 0);
    assign hit[i]    = (lane_fld_i == LANE_W'(i));
    // broadcast reads fall back to lane 0
    assign lane_o[i] = bcast ? (!rd_i || IS_L0) : hit[i];
  end

  assign valid_o = tgt_en_i && (bcast || (|hit)) && (32'(sel_i) < NUM_INST);
endmodule

// File: rtl/sdb_seq.sv
module sdb_seq
  import sdb_pkg::*;
#(
  parameter int TMO = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rd_i,
  input  logic ready_i,
  output logic busy_o,
  output logic we_o,
  output logic re_o,
  output logic done_o,
  output logic abort_o
);
  localparam int TW = $clog2(TMO + 1);

  seq_state_e    state_q;
  logic          op_rd_q;
  logic [TW-1:0] timer_q;
  logic          last;

  assign busy_o  = (state_q == SEQ_ACTIVE);
  assign we_o    = busy_o && !op_rd_q;
  assign re_o    = busy_o && op_rd_q;
  assign last    = (timer_q == TW'(TMO - 1));
  assign done_o  = busy_o && ready_i;
  assign abort_o = busy_o && !ready_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      op_rd_q <= 1'b0;
      timer_q <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        state_q <= SEQ_ACTIVE;
        op_rd_q <= rd_i;
        timer_q <= '0;
      end
    end else if (done_o || abort_o) begin
      state_q <= SEQ_IDLE;
    end else begin
      timer_q <= timer_q + 1'b1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && re_o)); // R2
  AST_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ready_i && !last) |=> busy_o); // R2
  AST_TIMER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (32'(timer_q) < TMO)); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !busy_o); // R8
endmodule

// File: rtl/sdb_bridge.sv
module sdb_bridge
  import sdb_pkg::*;
#(
  parameter int NUM_INST  = 4,
  parameter int NUM_LANES = 2,
  parameter int SEL_W     = 4,
  parameter int TMO       = 16,
  localparam int INST_W   = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 host_we_i,
  input  logic [1:0]           host_addr_i,
  input  logic [31:0]          host_wdata_i,
  output logic [31:0]          host_rdata_o,
  output logic [INST_W-1:0]    sd_inst_o,
  output logic [NUM_LANES-1:0] sd_lane_o,
  output logic [OFF_W-1:0]     sd_addr_o,
  output logic [OFF_W-1:0]     sd_wdata_o,
  output logic                 sd_we_o,
  output logic                 sd_re_o,
  input  logic                 sd_ready_i,
  input  logic [OFF_W-1:0]     sd_rdata_i
);
  logic [31:0]          addr_q;
  logic [SEL_W-1:0]     sel_q;
  logic [OFF_W-1:0]     data_q, rdata_q;
  logic                 wr_flag_q, rd_flag_q, rack_q, err_q;
  logic                 busy, done, abort, tgt_valid;
  logic                 wr_cmd, rd_cmd, accept, start;
  logic [NUM_LANES-1:0] lane_mask;

  assign wr_cmd = host_wdata_i[WR_FLAG_BIT] && !host_wdata_i[RD_FLAG_BIT];
  assign rd_cmd = !host_wdata_i[WR_FLAG_BIT] && host_wdata_i[RD_FLAG_BIT];
  assign accept = host_we_i && (host_addr_i == REG_CMD) && !busy && (wr_cmd || rd_cmd);
  assign start  = accept && tgt_valid;

  sdb_target_decode #(
    .NUM_LANES(NUM_LANES), .NUM_INST(NUM_INST), .SEL_W(SEL_W)
  ) u_dec (
    .tgt_en_i  (addr_q[TGT_EN_BIT]),
    .lane_fld_i(addr_q[LANE_LSB +: LANE_W]),
    .sel_i     (sel_q),
    .rd_i      (rd_flag_q),
    .lane_o    (lane_mask),
    .valid_o   (tgt_valid)
  );

  sdb_seq #(.TMO(TMO)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .rd_i   (rd_cmd),
    .ready_i(sd_ready_i),
    .busy_o (busy),
    .we_o   (sd_we_o),
    .re_o   (sd_re_o),
    .done_o (done),
    .abort_o(abort)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      sel_q     <= '0;
      data_q    <= '0;
      rdata_q   <= '0;
      wr_flag_q <= 1'b0;
      rd_flag_q <= 1'b0;
      rack_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (host_we_i && !busy && host_addr_i == REG_ADDR) addr_q <= host_wdata_i;
      if (host_we_i && !busy && host_addr_i == REG_SEL)  sel_q  <= host_wdata_i[SEL_W-1:0];
      if (host_we_i && host_addr_i == REG_STAT && host_wdata_i[ERR_BIT]) err_q <= 1'b0;
      if (accept) begin
        data_q    <= host_wdata_i[OFF_W-1:0];
        wr_flag_q <= wr_cmd && tgt_valid;
        rd_flag_q <= rd_cmd && tgt_valid;
        if (rd_cmd)     rack_q <= 1'b0;
        if (!tgt_valid) err_q  <= 1'b1;
      end
      if (done) begin
        wr_flag_q <= 1'b0;
        rd_flag_q <= 1'b0;
        if (rd_flag_q) begin
          rdata_q <= sd_rdata_i;
          rack_q  <= 1'b1;
        end
      end
      if (abort) begin
        wr_flag_q <= 1'b0;
        rd_flag_q <= 1'b0;
        err_q     <= 1'b1;
      end
    end
  end

  assign sd_inst_o  = sel_q[INST_W-1:0];
  assign sd_lane_o  = busy ? lane_mask : '0;
  assign sd_addr_o  = addr_q[OFF_W-1:0];
  assign sd_wdata_o = data_q;

  always_comb begin
    unique case (host_addr_i)
      REG_ADDR: host_rdata_o = addr_q;
      REG_CMD:  host_rdata_o = {wr_flag_q, rd_flag_q, 14'h0, data_q};
      REG_STAT: host_rdata_o = {rack_q, err_q, 14'h0, rdata_q};
      default:  host_rdata_o = {{(32-SEL_W){1'b0}}, sel_q};
    endcase
  end

  AST_RD_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_re_o |-> $onehot(sd_lane_o)); // R5
  AST_TGT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(sel_q) && $stable(data_q))); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done || abort) |=> (!wr_flag_q && !rd_flag_q)); // R2
  AST_RACK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && rd_flag_q) |=> rack_q); // R3
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> err_q); // R8
  AST_FLAG_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_flag_q || rd_flag_q) |-> busy); // R7
endmodule

// File: tb/tb_sdb_bridge.sv
module tb_sdb_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we_i = 1'b0;
  logic [1:0]  host_addr_i = '0;
  logic [31:0] host_wdata_i = '0;
  logic [31:0] host_rdata_o;
  logic [1:0]  sd_inst_o;
  logic [1:0]  sd_lane_o;
  logic [15:0] sd_addr_o, sd_wdata_o, sd_rdata_i;
  logic        sd_we_o, sd_re_o;
  logic        sd_ready_i = 1'b0;

  int errors = 0, checks = 0;
  int dly = 1, cnt = 0, txn = 0;
  logic [15:0] l_addr, l_wdata;
  logic [1:0]  l_lane, l_inst;
  logic        l_we;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdb_bridge #(.TMO(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(host_we_i), .host_addr_i(host_addr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o), .sd_inst_o(sd_inst_o),
    .sd_lane_o(sd_lane_o), .sd_addr_o(sd_addr_o), .sd_wdata_o(sd_wdata_o),
    .sd_we_o(sd_we_o), .sd_re_o(sd_re_o), .sd_ready_i(sd_ready_i), .sd_rdata_i(sd_rdata_i)
  );

  // SerDes model: read data folds in instance and lane mask
  assign sd_rdata_i = sd_addr_o ^ {sd_inst_o, 12'h0, sd_lane_o};

  always @(negedge clk) begin
    if (!rst_n) begin
      cnt = 0; sd_ready_i = 1'b0;
    end else if (sd_we_o || sd_re_o) begin
      cnt = cnt + 1;
      if (dly != 0 && cnt >= dly && !sd_ready_i) begin
        sd_ready_i = 1'b1;
        txn = txn + 1;
        l_addr = sd_addr_o; l_wdata = sd_wdata_o; l_lane = sd_lane_o;
        l_inst = sd_inst_o; l_we = sd_we_o;
      end
    end else begin
      cnt = 0; sd_ready_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr_i = a; host_wdata_i = d; host_we_i = 1'b1;
    @(negedge clk);
    host_we_i = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [31:0] v);
    host_addr_i = a;
    #1;
    v = host_rdata_o;
  endtask

  // issue a command, count polls with the flag still set
  task automatic run_cmd(input logic [31:0] w, input int bitpos, output int polls);
    logic [31:0] v;
    hwrite(2'd1, w);
    polls = 0;
    for (int k = 0; k < 200; k++) begin
      hread(2'd1, v);
      if (!v[bitpos]) break;
      polls++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, aw, exp;
    logic [8:0]  lane;
    logic [15:0] off, wd;
    logic [1:0]  mask;
    int polls, t0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 4; r++) begin
      hread(2'(r), v);
      chk(v == 0, "R1 reg reset", v, 0);
    end
    chk(!sd_we_o && !sd_re_o && sd_lane_o == 0, "R1 strobes", {sd_we_o, sd_re_o, sd_lane_o}, 0);

    // sweep: instance x lane code x operation
    for (int inst = 0; inst < 4; inst++) begin
      hwrite(2'd3, 32'(inst));
      for (int li = 0; li < 3; li++) begin
        for (int op = 0; op < 2; op++) begin
          lane = (li == 2) ? 9'h1FF : 9'(li);
          off  = 16'h1000 + 16'(inst * 16 + li * 4 + op);
          wd   = 16'hA500 ^ off;
          aw   = (32'h1 << 27) | (32'(lane) << 16) | 32'(off);
          mask = (li == 0) ? 2'b01 : (li == 1) ? 2'b10 : (op == 1 ? 2'b01 : 2'b11);
          dly  = 1 + ((inst + li + op) % 3);
          hwrite(2'd0, aw);
          t0 = txn;
          if (op == 0) run_cmd({2'b10, 14'h0, wd}, 31, polls);
          else         run_cmd({2'b01, 14'h0, wd}, 30, polls);
          chk(polls == dly, "R2 flag latency", polls, dly);
          chk(txn == t0 + 1, "R2 one transaction", txn, t0 + 1);
          chk(l_addr == off && l_we == (op == 0), "R2 offset/op", {l_addr, 15'h0, l_we}, {off, 15'h0, op == 0});
          chk(l_lane == mask, (li == 2 && op == 1) ? "R5 bcast read lane" : "R4 lane mask", l_lane, mask);
          chk(l_inst == 2'(inst), "R6 instance", l_inst, inst);
          if (op == 0) chk(l_wdata == wd, "R2 write data", l_wdata, wd);
          else begin
            hread(2'd2, v);
            exp = {1'b1, 1'b0, 14'h0, off ^ {2'(inst), 12'h0, mask}};
            chk(v == exp, "R3 read data/ack", v, exp);
          end
        end
      end
    end

    // R11: both flags / no flag
    hread(2'd1, exp);
    t0 = txn;
    hwrite(2'd1, 32'hC000_1234);
    hwrite(2'd1, 32'h0000_5678);
    @(negedge clk); #1;
    hread(2'd1, v);
    chk(v == exp && txn == t0 && !sd_we_o && !sd_re_o, "R11 no command", v, exp);

    // R7: invalid targets
    dly = 1;
    hwrite(2'd3, 32'd0);
    for (int c = 0; c < 3; c++) begin
      if (c == 0) hwrite(2'd0, 32'h0000_0010);
      if (c == 1) hwrite(2'd0, 32'h0802_0010);
      if (c == 2) begin hwrite(2'd0, 32'h0800_0010); hwrite(2'd3, 32'd5); end
      t0 = txn;
      run_cmd(32'h8000_0001, 31, polls);
      hread(2'd2, v);
      chk(polls == 0 && v[30] && txn == t0, "R7 refused target", {polls[15:0], 15'h0, v[30]}, 32'h1);
      hwrite(2'd2, 32'h4000_0000);
      hread(2'd2, v);
      chk(!v[30], "R12 error clear", v, 0);
    end
    hwrite(2'd3, 32'd1);
    hwrite(2'd0, 32'h0800_0020);

    // R8: ready on last allowed cycle, then never
    dly = TMO;
    t0 = txn;
    run_cmd(32'h8000_0055, 31, polls);
    hread(2'd2, v);
    chk(polls == TMO && txn == t0 + 1 && !v[30], "R8 last-cycle ready", polls, TMO);
    dly = 0;
    run_cmd(32'h8000_0066, 31, polls);
    hread(2'd2, v);
    chk(polls == TMO && v[30] && txn == t0 + 1, "R8 timeout abort", {polls[15:0], 15'h0, v[30]}, {16'(TMO), 16'h1});
    chk(!sd_we_o && !sd_re_o, "R8 strobe dropped", {sd_we_o, sd_re_o}, 0);
    hwrite(2'd2, 32'h4000_0000);

    // R9: writes during a running command are ignored
    dly = 6;
    hwrite(2'd0, 32'h0800_0077);
    t0 = txn;
    hwrite(2'd1, 32'h8000_0111);
    hwrite(2'd1, 32'h8000_0222);
    hwrite(2'd0, 32'h0801_0099);
    hwrite(2'd3, 32'd2);
    repeat (6) @(negedge clk);
    #1;
    chk(txn == t0 + 1 && l_addr == 16'h0077 && l_wdata == 16'h0111, "R9 command kept",
        {l_addr, l_wdata}, 32'h0077_0111);
    hread(2'd0, v);
    chk(v == 32'h0800_0077, "R9 address kept", v, 32'h0800_0077);
    hread(2'd3, v);
    chk(v == 32'd1, "R9 select kept", v, 1);

    // R10: new read clears acknowledge at acceptance
    dly = 1;
    run_cmd(32'h4000_0000, 30, polls);
    hread(2'd2, v);
    chk(v[31], "R3 ack set", v, 32'h8000_0000);
    dly = 3;
    hwrite(2'd1, 32'h4000_0000);
    #1;
    hread(2'd2, v);
    chk(!v[31], "R10 ack cleared on issue", v, 0);
    repeat (4) @(negedge clk);
    #1;
    hread(2'd2, v);
    chk(v[31], "R10 ack after completion", v, 32'h8000_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule